// File: doc/BRIEF.md
# Sequential Multiply-Accumulate FIR Filter

This block evaluates one output of a finite impulse response filter with a parameterized number of taps. It does not build a full multiplier tree. A single multiplier and a single accumulator are reused, and each clock cycle adds one coefficient-times-sample product. A small controller steps an index through the taps.

Samples enter a shift line through a strobe. Coefficients are loaded through a simple indexed write port. A one-cycle start pulse launches the evaluation on whatever the line holds at that moment. A one-cycle ready pulse marks the point where the sum on the result port is final. While an evaluation runs, the sample line and the coefficient bank are frozen, and further starts are ignored. The sum therefore always refers to one consistent set of inputs.

The accumulator width is derived from the sample width, the coefficient width and the tap count. A full sum of worst-case products never wraps.

Top module: `fir_seq_mac`

## Requirements
- R1: After reset, ready is 0, result is 0, and every tap and coefficient holds 0. An evaluation started right after reset yields 0 even when the coefficients have since been written with nonzero values.
- R2: The result is the sum over k = 0..TAPS-1 of coef[k] times tap[k]. Tap 0 is the most recently accepted sample and tap k is the sample accepted k strobes earlier. With SIGNED_DATA=1, samples, coefficients and result are two's complement.
- R3: Ready is high for exactly one cycle. It rises on the TAPS-th rising edge after the edge that samples an accepted start.
- R4: The accumulator is cleared when a start is accepted, so a result never includes terms of an earlier evaluation.
- R5: From the ready pulse until the next accepted start, result stays unchanged.
- R6: A start that arrives while an evaluation is running is ignored: there is no extra ready pulse and no restart.
- R7: A sample strobe during a running evaluation is ignored, and the tap line keeps its contents.
- R8: When a sample strobe and a start coincide while idle, the sample is shifted in first, and the evaluation includes it as tap 0.
- R9: A write with coef_we=1 stores coef_data at index coef_addr, where index 0 pairs with tap 0. A write during a running evaluation is ignored.
- R10: The result never overflows. With every sample and coefficient at the most negative value, the result equals TAPS times the square of that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Strobe that shifts smp_data into the tap line |
| smp_data | input | DW | New input sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | IW | Coefficient index (0 pairs with the newest tap) |
| coef_data | input | CW | Coefficient value to store |
| start | input | 1 | Launches one evaluation when idle |
| ready | output | 1 | One-cycle pulse: result is final |
| result | output | AW | Accumulated filter output |

## Verification
The embedded properties run on every cycle and cover four areas:
- Ready is a single-cycle pulse that only ends a running evaluation.
- The accumulator reads zero one cycle after an accepted start.
- The result is held while the block is idle without a start.
- A start during a running evaluation does not rewind the tap index, and the tap line and coefficient bank do not move while their enables are off.

Only the bench scenarios can show the arithmetic itself: correct sums for tabled and random data, the exact TAPS-cycle latency, the ordering of a simultaneous sample and start, and the absence of overflow at the extremes.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;

   // Minimum accumulator width that holds TAPS full-precision products.
   function automatic int acc_width(input int dw, input int cw, input int taps);
      return dw + cw + $clog2(taps);
   endfunction

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

endpackage

// File: rtl/fir_tap_line.sv
module fir_tap_line #(
   parameter int TAPS = 4,
   parameter int DW   = 8,
   localparam int IW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic [DW-1:0] din,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] dout
);

   logic [TAPS*DW-1:0] line_q;

   for (genvar k = 0; k < TAPS; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_q[k*DW +: DW] <= '0;
         end else if (shift_en) begin
            if (k == 0) begin
               line_q[k*DW +: DW] <= din;
            end else begin
               line_q[k*DW +: DW] <= line_q[(k-1)*DW +: DW];
            end
         end
      end
   end

   assign dout = line_q[rd_idx*DW +: DW];

   AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(line_q)); // R7

endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
   parameter int TAPS = 4,
   parameter int CW   = 8,
   localparam int IW  = (TAPS > 1) ? $clog2(TAPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [CW-1:0] wdata,
   input  logic [IW-1:0] rd_idx,
   output logic [CW-1:0] dout
);

   logic [TAPS*CW-1:0] bank_q;

   for (genvar k = 0; k < TAPS; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q[k*CW +: CW] <= '0;
         end else if (we && (waddr == IW'(k))) begin
            bank_q[k*CW +: CW] <= wdata;
         end
      end
   end

   assign dout = bank_q[rd_idx*CW +: CW];

   AST_COEF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(bank_q)); // R9

endmodule

// File: rtl/fir_mac_ctrl.sv
module fir_mac_ctrl
   import fir_seq_pkg::*;
#(
   parameter int TAPS        = 4,
   parameter int DW          = 8,
   parameter int CW          = 8,
   parameter int AW          = 18,
   parameter bit SIGNED_DATA = 1'b1,
   localparam int IW         = (TAPS > 1) ? $clog2(TAPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] sample_i,
   input  logic [CW-1:0] coef_i,
   output logic [IW-1:0] idx_o,
   output logic          busy_o,
   output logic          ready_o,
   output logic [AW-1:0] acc_o
);

   localparam int PW = DW + CW;

   seq_state_e    state_q;
   logic [IW-1:0] idx_q;
   logic [AW-1:0] acc_q;
   logic          ready_q;
   logic [AW-1:0] prod_ext;
   logic          last;

   if (SIGNED_DATA) begin : g_signed
      logic signed [PW-1:0] prod;
      assign prod     = $signed(sample_i) * $signed(coef_i);
      assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
   end else begin : g_unsigned
      logic [PW-1:0] prod;
      assign prod     = PW'(sample_i) * PW'(coef_i);
      assign prod_ext = {{(AW-PW){1'b0}}, prod};
   end

   assign last = (idx_q == IW'(TAPS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         acc_q   <= '0;
         ready_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  acc_q   <= '0;
                  idx_q   <= '0;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               acc_q <= acc_q + prod_ext;
               if (last) begin
                  state_q <= ST_IDLE;
                  ready_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + IW'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign idx_o   = idx_q;
   assign busy_o  = (state_q == ST_RUN);
   assign ready_o = ready_q;
   assign acc_o   = acc_q;

   initial begin
      assert (TAPS >= 2) else $error("fir_mac_ctrl: TAPS must be at least 2");
      assert (AW >= acc_width(DW, CW, TAPS)) else $error("fir_mac_ctrl: AW too narrow");
   end

   AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> !ready_q); // R3
   AST_READY_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |-> $past(busy_o)); // R3
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (acc_q == '0)); // R4
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(acc_q)); // R5
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !last) |=> (idx_q != '0)); // R6

endmodule

// File: rtl/fir_seq_mac.sv
module fir_seq_mac
   import fir_seq_pkg::*;
#(
   parameter int TAPS        = 4,
   parameter int DW          = 8,
   parameter int CW          = 8,
   parameter bit SIGNED_DATA = 1'b1,
   parameter int AW          = acc_width(DW, CW, TAPS),
   localparam int IW         = (TAPS > 1) ? $clog2(TAPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_data,
   input  logic          coef_we,
   input  logic [IW-1:0] coef_addr,
   input  logic [CW-1:0] coef_data,
   input  logic          start,
   output logic          ready,
   output logic [AW-1:0] result
);

   logic [IW-1:0] idx;
   logic          busy;
   logic [DW-1:0] cur_sample;
   logic [CW-1:0] cur_coef;
   logic          shift_en;
   logic          coef_wr;

   assign shift_en = smp_valid && !busy;
   assign coef_wr  = coef_we && !busy;

   fir_tap_line #(.TAPS(TAPS), .DW(DW)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (smp_data),
      .rd_idx   (idx),
      .dout     (cur_sample)
   );

   fir_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (coef_wr),
      .waddr  (coef_addr),
      .wdata  (coef_data),
      .rd_idx (idx),
      .dout   (cur_coef)
   );

   fir_mac_ctrl #(
      .TAPS(TAPS), .DW(DW), .CW(CW), .AW(AW), .SIGNED_DATA(SIGNED_DATA)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .sample_i (cur_sample),
      .coef_i   (cur_coef),
      .idx_o    (idx),
      .busy_o   (busy),
      .ready_o  (ready),
      .acc_o    (result)
   );

endmodule

// File: tb/fir_seq_mac_bench.sv
module fir_seq_mac_bench;

   localparam int TAPS = 4;
   localparam int DW   = 8;
   localparam int CW   = 8;
   localparam int AW   = 18;
   localparam int IW   = 2;
   localparam int NVEC = 6;

   // Each entry: {c0,c1,c2,c3, s_first,s2,s3,s_last}; s_last becomes tap 0.
   localparam logic [63:0] VEC_TAB [NVEC] = '{
      64'h01_00_00_00_05_06_07_08,
      64'h01_01_01_01_01_02_03_04,
      64'hFF_02_FE_03_10_F0_20_E0,
      64'h7F_7F_7F_7F_7F_7F_7F_7F,
      64'h80_7F_01_FF_7F_80_FF_01,
      64'h00_00_00_0A_33_00_00_00
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic [DW-1:0] smp_data = '0;
   logic          coef_we = 1'b0;
   logic [IW-1:0] coef_addr = '0;
   logic [CW-1:0] coef_data = '0;
   logic          start = 1'b0;
   logic          ready;
   logic [AW-1:0] result;

   logic signed [DW-1:0] m_tap [TAPS];
   logic signed [CW-1:0] m_coef [TAPS];
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fir_seq_mac #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_fir_seq_mac (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
      .start(start), .ready(ready), .result(result)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic signed [AW-1:0] model_sum();
      logic signed [AW-1:0] s = '0;
      for (int k = 0; k < TAPS; k++) s = s + m_coef[k] * m_tap[k];
      return s;
   endfunction

   function automatic void model_push(input logic [DW-1:0] v);
      for (int k = TAPS - 1; k > 0; k--) m_tap[k] = m_tap[k-1];
      m_tap[0] = v;
   endfunction

   task automatic write_coef(input int k, input logic [CW-1:0] v);
      coef_we = 1'b1; coef_addr = IW'(k); coef_data = v;
      @(negedge clk);
      coef_we = 1'b0;
      m_coef[k] = v;
   endtask

   task automatic push(input logic [DW-1:0] v);
      smp_valid = 1'b1; smp_data = v;
      @(negedge clk);
      smp_valid = 1'b0;
      model_push(v);
   endtask

   // mode: 0 plain, 1 extra start, 2 sample while busy, 3 coef write while busy,
   // 4 sample together with start
   task automatic do_run(input int mode, input logic [DW-1:0] extra, input string tag);
      logic signed [AW-1:0] exp;
      int waited;
      int bad;
      start = 1'b1;
      if (mode == 4) begin
         smp_valid = 1'b1; smp_data = extra; model_push(extra);
      end
      exp = model_sum();
      @(negedge clk);
      start = 1'b0; smp_valid = 1'b0;
      waited = 0;
      while (!ready && waited < 3 * TAPS) begin
         if (waited == 1) begin
            case (mode)
               1: start = 1'b1;
               2: begin smp_valid = 1'b1; smp_data = extra; end
               3: begin coef_we = 1'b1; coef_addr = '0; coef_data = extra; end
               default: ;
            endcase
         end
         @(negedge clk);
         start = 1'b0; smp_valid = 1'b0; coef_we = 1'b0;
         waited++;
      end
      chk({"R3 latency ", tag}, waited, TAPS);
      chk({"R2 sum ", tag}, $signed(result), exp);
      bad = 0;
      for (int c = 0; c < TAPS + 2; c++) begin
         @(negedge clk);
         if (ready || $signed(result) != exp) bad++;
      end
      chk({"R5 hold / R6 single ready ", tag}, bad, 0);
   endtask

   initial begin
      for (int k = 0; k < TAPS; k++) begin m_tap[k] = '0; m_coef[k] = '0; end
      repeat (3) @(negedge clk);
      chk("R1 ready after reset", ready, 0);
      chk("R1 result after reset", result, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < TAPS; k++) write_coef(k, CW'(k + 1));
      do_run(0, '0, "R1 zero taps");

      for (int v = 0; v < NVEC; v++) begin
         for (int k = 0; k < TAPS; k++) write_coef(k, VEC_TAB[v][63 - 8*k -: 8]);
         for (int k = 0; k < TAPS; k++) push(VEC_TAB[v][31 - 8*k -: 8]);
         do_run(0, '0, "R2 table");
      end
      do_run(0, '0, "R4 rerun not doubled");

      for (int r = 0; r < 20; r++) begin
         for (int k = 0; k < TAPS; k++) write_coef(k, CW'($urandom));
         for (int k = 0; k < TAPS; k++) push(DW'($urandom));
         do_run(0, '0, "R2 random");
      end

      do_run(1, '0, "R6 start while busy");
      do_run(2, 8'h55, "R7 sample while busy");
      do_run(0, '0, "R7 taps unchanged");
      do_run(3, 8'h40, "R9 coef write while busy");
      do_run(0, '0, "R9 coef unchanged");
      do_run(4, 8'h23, "R8 sample with start");

      for (int k = 0; k < TAPS; k++) write_coef(k, 8'h80);
      for (int k = 0; k < TAPS; k++) push(8'h80);
      do_run(0, '0, "R10 extremes");
      chk("R10 extreme value", $signed(result), TAPS * 16384);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule